// File: doc/BRIEF.md
# Four-Line Feeder Control Interface

This block is the host-side front end of a controller that switches power onto four subscriber lines. A processor reaches it through a 4-bit bus with chip select, read and write strobes, and one address bit. The address bit can be multiplexed and captured by an address strobe, or the address strobe can be held high for a plain bus. One address reaches a pointer register. The other reaches the line enable register on writes, and on reads the status group that the pointer selects.

Four analog detectors per line are seen here as digital flags: low voltage, open loop, current overload and thermal overload. A thermal overload removes the drive from its line at once. The drive comes back only after the flag has stayed clear for a programmable number of clock cycles. The active-low interrupt is not latched. It follows the current-overload flags of lines that are being driven, gated by an enable bit in the pointer register.

All host signals are taken to be synchronous to `clk`. A write takes effect on the first clock edge of a write access, and read data is combinational while the access is open.

Top module: `lfc_feeder_ctl`

## Requirements
- R1: While `rst` is high and after it falls, every register is zero: `line_on` is 0000, `irq_n` is 1, `d_oe` is 0 and a read at address 0 returns 0000.
- R2: A write access (`cs_n`=0, `wr_n`=0) at effective address 1 loads `d_in` into the line enable register. Bit n enables line n, and `line_on` shows the new value after the first clock edge of the access.
- R3: A write access at effective address 0 loads `d_in` into the pointer register. A read at address 0 returns pointer bits 2..0 on D2..D0 and, on D3, the OR of all four lines' thermal-disable flags.
- R4: A read at address 1 returns the group that pointer bits 2..0 select, with bit n for line n. Code 0 is low voltage, 1 is open loop, 2 is current overload ANDed with `line_on`, and 3 is the thermal-disable flags. Codes 4..7 read 0000.
- R5: `d_oe` is 1 only while `cs_n` and `rd_n` are both 0. When it is 0, `d_out` is 0000.
- R6: The effective address follows `a0` while `ale` is 1. Once `ale` falls, it holds the last value that `a0` had while `ale` was 1.
- R7: A high `hot_in[n]` at a clock edge sets line n's thermal-disable flag, and `line_on[n]` = enable bit AND NOT flag. The flag clears at the RECOV_CYCLES-th consecutive edge at which `hot_in[n]` is low. A high sample restarts the count.
- R8: `irq_n` is 0 exactly when pointer bit 3 is 1 and some line n has both `ovld_in[n]` and `line_on[n]` set. With pointer bit 3 at 0, `irq_n` stays 1.
- R9: Clearing a line's enable bit, or a thermal disable of that line, takes that line's overload out of the interrupt.
- R10: With `cs_n` at 1, a low `wr_n` changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, active high, asynchronous assert |
| ale | input | 1 | Address strobe; address transparent while high |
| a0 | input | 1 | Address bit |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| d_in | input | 4 | Write data from host |
| d_out | output | 4 | Read data to host |
| d_oe | output | 1 | Read data drive enable |
| lowv_in | input | 4 | Low-voltage flag per line |
| open_in | input | 4 | Open-loop flag per line |
| ovld_in | input | 4 | Current-overload flag per line |
| hot_in | input | 4 | Thermal-overload flag per line |
| line_on | output | 4 | Drive enable per line |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two things can land in the same cycle. A thermal trip can arrive while an enabled line's overload is already pulling the interrupt low, and a new thermal sample can come on the very edge at which the recovery count would expire. The bench raises `hot_in` on a line that is already interrupting and checks at the next falling edge that `irq_n` has returned high and the drive is off. It also raises the flag again partway through a recovery and checks that the drive stays off for a full fresh RECOV_CYCLES window, then comes back on exactly one edge later.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned NLINE = 4;
  localparam int unsigned DW    = 4;
  localparam int unsigned SELW  = 3;

  typedef enum logic [SELW-1:0] {
    SEL_LOWV = 3'd0,
    SEL_OPEN = 3'd1,
    SEL_OVLD = 3'd2,
    SEL_HOT  = 3'd3
  } sel_e;
endpackage

// File: rtl/lfc_rst_sync.sv
module lfc_rst_sync (
  input  logic clk,
  input  logic rst,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/lfc_host_regs.sv
module lfc_host_regs
  import lfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          a0,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [DW-1:0] d_in,
  output logic          a0_eff,
  output logic [DW-1:0] iar,
  output logic [DW-1:0] ler
);
  logic          a0_hold_q, a0_hold_nx;
  logic          wr_act, wr_act_q, wr_stb;
  logic [DW-1:0] iar_q, iar_nx;
  logic [DW-1:0] ler_q, ler_nx;

  always_comb begin
    a0_eff = ale ? a0 : a0_hold_q;
    wr_act = !cs_n && !wr_n;
    wr_stb = wr_act && !wr_act_q;
  end

  always_comb begin
    a0_hold_nx = a0_hold_q;
    iar_nx     = iar_q;
    ler_nx     = ler_q;
    if (ale) a0_hold_nx = a0;
    if (wr_stb) begin
      if (a0_eff) ler_nx = d_in;
      else        iar_nx = d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_hold_q <= 1'b0;
      wr_act_q  <= 1'b0;
      iar_q     <= '0;
      ler_q     <= '0;
    end else begin
      a0_hold_q <= a0_hold_nx;
      wr_act_q  <= wr_act;
      iar_q     <= iar_nx;
      ler_q     <= ler_nx;
    end
  end

  assign iar = iar_q;
  assign ler = ler_q;

  assert_ler_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !wr_act_q && a0_eff) |=> (ler_q == $past(d_in)));

  assert_iar_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !wr_act_q && !a0_eff) |=> (iar_q == $past(d_in)));

  assert_no_write_without_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(ler_q) && $stable(iar_q)));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(a0_hold_q));
endmodule

// File: rtl/lfc_thermal_guard.sv
module lfc_thermal_guard
  import lfc_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] hot_in,
  output logic [NLINE-1:0] tdis
);
  localparam int unsigned CW = $clog2(RECOV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_CYCLES - 1);

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    logic          flag_q, flag_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    always_comb begin
      flag_nx = flag_q;
      cnt_nx  = cnt_q;
      if (hot_in[n]) begin
        flag_nx = 1'b1;
        cnt_nx  = '0;
      end else if (flag_q) begin
        if (cnt_q == LAST) begin
          flag_nx = 1'b0;
          cnt_nx  = '0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        flag_q <= flag_nx;
        cnt_q  <= cnt_nx;
      end
    end

    assign tdis[n] = flag_q;

    assert_trip_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hot_in[n] |=> tdis[n]);

    assert_clear_only_when_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdis[n]) |-> !$past(hot_in[n]));
  end
endmodule

// File: rtl/lfc_readout.sv
module lfc_readout
  import lfc_pkg::*;
(
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             a0_eff,
  input  logic [DW-1:0]    iar,
  input  logic [NLINE-1:0] lowv,
  input  logic [NLINE-1:0] open,
  input  logic [NLINE-1:0] ovld_m,
  input  logic [NLINE-1:0] tdis,
  output logic [DW-1:0]    d_out,
  output logic             d_oe
);
  logic [DW-1:0] grp;
  logic [DW-1:0] ptr_word;
  sel_e          sel;

  always_comb begin
    sel = sel_e'(iar[SELW-1:0]);
    case (sel)
      SEL_LOWV: grp = lowv;
      SEL_OPEN: grp = open;
      SEL_OVLD: grp = ovld_m;
      SEL_HOT:  grp = tdis;
      default:  grp = '0;
    endcase
    ptr_word = {|tdis, iar[SELW-1:0]};
    d_oe     = !cs_n && !rd_n;
    d_out    = d_oe ? (a0_eff ? grp : ptr_word) : '0;
  end
endmodule

// File: rtl/lfc_feeder_ctl.sv
module lfc_feeder_ctl
  import lfc_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 20000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic             a0,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    d_in,
  output logic [DW-1:0]    d_out,
  output logic             d_oe,
  input  logic [NLINE-1:0] lowv_in,
  input  logic [NLINE-1:0] open_in,
  input  logic [NLINE-1:0] ovld_in,
  input  logic [NLINE-1:0] hot_in,
  output logic [NLINE-1:0] line_on,
  output logic             irq_n
);
  localparam int unsigned IRQ_EN_BIT = DW - 1;

  logic             rst_n;
  logic             a0_eff;
  logic [DW-1:0]    iar;
  logic [DW-1:0]    ler;
  logic [NLINE-1:0] tdis;
  logic [NLINE-1:0] ovld_m;

  lfc_rst_sync u_rst (
    .clk   (clk),
    .rst   (rst),
    .rst_n (rst_n)
  );

  lfc_host_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .a0     (a0),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .d_in   (d_in),
    .a0_eff (a0_eff),
    .iar    (iar),
    .ler    (ler)
  );

  lfc_thermal_guard #(.RECOV_CYCLES(RECOV_CYCLES)) u_therm (
    .clk    (clk),
    .rst_n  (rst_n),
    .hot_in (hot_in),
    .tdis   (tdis)
  );

  always_comb begin
    line_on = ler[NLINE-1:0] & ~tdis;
    ovld_m  = ovld_in & line_on;
    irq_n   = !(iar[IRQ_EN_BIT] && (|ovld_m));
  end

  lfc_readout u_rd (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .a0_eff (a0_eff),
    .iar    (iar),
    .lowv   (lowv_in),
    .open   (open_in),
    .ovld_m (ovld_m),
    .tdis   (tdis),
    .d_out  (d_out),
    .d_oe   (d_oe)
  );

  assert_idle_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!d_oe && d_out == '0));

  assert_mask_holds_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !iar[IRQ_EN_BIT] |-> irq_n);

  assert_dark_lines_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_on == '0) |-> irq_n);

  assert_tripped_line_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hot_in[0]) |-> !line_on[0]);
endmodule

// File: tb/lfc_feeder_ctl_tb.sv
module lfc_feeder_ctl_tb;
  localparam int REC = 6;

  logic       clk, rst, ale, a0, cs_n, rd_n, wr_n;
  logic [3:0] d_in, d_out, lowv_in, open_in, ovld_in, hot_in, line_on;
  logic       d_oe, irq_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lfc_feeder_ctl #(.RECOV_CYCLES(REC)) u_dut (
    .clk(clk), .rst(rst), .ale(ale), .a0(a0), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .lowv_in(lowv_in), .open_in(open_in), .ovld_in(ovld_in),
    .hot_in(hot_in), .line_on(line_on), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [3:0] val);
    @(negedge clk);
    a0 = addr; d_in = val; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input bit set_addr, input logic addr, output logic [3:0] v);
    @(negedge clk);
    if (set_addr) a0 = addr;
    cs_n = 1'b0; rd_n = 1'b0;
    #1 v = d_out;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [3:0] v;
    chk("R1 line_on", line_on, 4'h0);
    chk("R1 irq_n", {3'b0, irq_n}, 4'h1);
    chk("R1 d_oe idle", {3'b0, d_oe}, 4'h0);
    rd(1, 1'b0, v);
    chk("R1 ptr read", v, 4'h0);
  endtask

  task automatic t_regs;
    logic [3:0] v;
    wr(1'b1, 4'hA);
    chk("R2 line_on after write", line_on, 4'hA);
    wr(1'b0, 4'h5);
    rd(1, 1'b0, v);
    chk("R3 ptr read", v, 4'h5);
    chk("R2 ler kept by ptr write", line_on, 4'hA);
  endtask

  task automatic t_bus;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 chk("R5 oe with cs high", {3'b0, d_oe}, 4'h0);
    chk("R5 data with cs high", d_out, 4'h0);
    cs_n = 1'b0; rd_n = 1'b1;
    #1 chk("R5 oe with rd high", {3'b0, d_oe}, 4'h0);
    rd_n = 1'b0;
    #1 chk("R5 oe both low", {3'b0, d_oe}, 4'h1);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_groups;
    logic [3:0] v;
    lowv_in = 4'h3; open_in = 4'hC; ovld_in = 4'h6;
    wr(1'b1, 4'hF);
    wr(1'b0, 4'h0); rd(1, 1'b1, v); chk("R4 code0 lowv", v, 4'h3);
    wr(1'b0, 4'h1); rd(1, 1'b1, v); chk("R4 code1 open", v, 4'hC);
    wr(1'b0, 4'h2); rd(1, 1'b1, v); chk("R4 code2 ovld", v, 4'h6);
    wr(1'b1, 4'h2); rd(1, 1'b1, v); chk("R4 code2 masked by enable", v, 4'h2);
    wr(1'b0, 4'h3); rd(1, 1'b1, v); chk("R4 code3 hot none", v, 4'h0);
    wr(1'b0, 4'h5); rd(1, 1'b1, v); chk("R4 code5 zero", v, 4'h0);
    ovld_in = 4'h0;
  endtask

  task automatic t_ale;
    logic [3:0] v;
    wr(1'b0, 4'h0);
    lowv_in = 4'h9;
    @(negedge clk); ale = 1'b1; a0 = 1'b1;
    @(negedge clk); ale = 1'b0; a0 = 1'b0;
    rd(0, 1'b0, v);
    chk("R6 held address 1", v, 4'h9);
    @(negedge clk); ale = 1'b1; a0 = 1'b0;
    @(negedge clk); ale = 1'b0; a0 = 1'b1;
    rd(0, 1'b0, v);
    chk("R6 held address 0", v, 4'h0);
    @(negedge clk); ale = 1'b1;
  endtask

  task automatic t_nocs;
    wr(1'b1, 4'h7);
    @(negedge clk);
    a0 = 1'b1; d_in = 4'h0; cs_n = 1'b1; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    chk("R10 no write without cs", line_on, 4'h7);
  endtask

  task automatic t_irq;
    wr(1'b1, 4'hF);
    ovld_in = 4'h1;
    wr(1'b0, 4'h8);
    chk("R8 irq asserted", {3'b0, irq_n}, 4'h0);
    wr(1'b0, 4'h0);
    chk("R8 irq masked", {3'b0, irq_n}, 4'h1);
    wr(1'b0, 4'h8);
    wr(1'b1, 4'hE);
    chk("R9 irq off by enable clear", {3'b0, irq_n}, 4'h1);
    wr(1'b1, 4'hF);
    chk("R8 irq back", {3'b0, irq_n}, 4'h0);
    @(negedge clk); hot_in = 4'h1;
    @(negedge clk);
    chk("R9 irq off by thermal trip", {3'b0, irq_n}, 4'h1);
    chk("R7 line0 dark", line_on, 4'hE);
    hot_in = 4'h0;
    repeat (REC + 1) @(negedge clk);
    ovld_in = 4'h0;
    wr(1'b0, 4'h0);
  endtask

  task automatic t_therm;
    logic [3:0] v;
    wr(1'b1, 4'hF);
    @(negedge clk); hot_in = 4'h4;
    @(negedge clk);
    chk("R7 line2 tripped", line_on, 4'hB);
    rd(1, 1'b0, v);
    chk("R3 thermal status bit", v, 4'h8);
    wr(1'b0, 4'h3);
    rd(1, 1'b1, v);
    chk("R4 hot group", v, 4'h4);
    @(negedge clk); hot_in = 4'h0;
    repeat (REC - 1) @(negedge clk);
    chk("R7 still dark before window end", line_on, 4'hB);
    @(negedge clk);
    chk("R7 recovered at window end", line_on, 4'hF);
    @(negedge clk); hot_in = 4'h4;
    @(negedge clk); hot_in = 4'h0;
    repeat (3) @(negedge clk);
    hot_in = 4'h4;
    @(negedge clk); hot_in = 4'h0;
    repeat (REC - 1) @(negedge clk);
    chk("R7 retrigger restarts window", line_on, 4'hB);
    @(negedge clk);
    chk("R7 recovered after retrigger", line_on, 4'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ale = 1'b1; a0 = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    d_in = 4'h0; lowv_in = 4'h0; open_in = 4'h0; ovld_in = 4'h0; hot_in = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 line_on in reset", line_on, 4'h0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_bus;
    t_groups;
    t_ale;
    t_nocs;
    t_irq;
    t_therm;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule